// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block holds the current date and time as packed BCD registers: seconds, minutes, hours, day of month, weekday, month and a two-digit year that spans 2000 to 2099. A sub-second prescaler counts oscillator pulses on `osc_tick`. Every `PRESCALE` pulses it produces one second step, and that step ripples through all fields. The day rollover follows the real month lengths and the leap-year rule of that century.

A host reaches the block through single-cycle write and read strobes on a small register space. A control register holds a run/freeze bit and a 12/24-hour display select. Writing a reserved command pattern to the control register restores the power-on state. Bit 7 of the seconds register is a sticky "time not trustworthy" flag. Power-on reset and the command reset set it. Only the host clears it, by loading the seconds register.

The normal way to load the time is to freeze counting, write the fields and then release the freeze. The first second after release arrives one full prescaler period later.

Top module: `bcd_timekeeper`

## Requirements
- R1: On a cycle with `rd_en` high, `rdata` presents the addressed register on the next cycle and holds it until the next read. Address 0x0 reads as control, with bit 5 the freeze bit, bit 2 the 12-hour select and every other bit 0. Addresses 0x2 to 0x8 hold seconds, minutes, hours, day of month, weekday, month and year, in that order. All other addresses read 0x00, and writes to them change nothing.
- R2: After `rst` the time is 00:00:00, day 01, weekday 0, month 01, year 00. Seconds read 0x80 because the not-valid flag is set, and control reads 0x00.
- R3: Each second step increments the seconds. Seconds 59 wraps to 00 and carries into the minutes, minutes 59 wraps to 00 and carries into the hours, and hour 23 wraps to 00 and carries into the day.
- R4: The day wraps from 30 to 01 in months 4, 6, 9 and 11, and from 31 to 01 in months 1, 3, 5, 7, 8, 10 and 12. Below the month's length the day simply increments.
- R5: February (month 2) wraps after day 29 when the year is divisible by 4, and after day 28 in all other years.
- R6: A day wrap increments the month. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R7: The weekday is binary, 0 to 6. It increments on every day change and wraps from 6 to 0.
- R8: While control bit 5 is 1, no field changes except through host writes, and the prescaler is held at zero. After bit 5 clears, the first second step comes exactly `PRESCALE` `osc_tick` pulses later, whatever partial count was held before the freeze.
- R9: The not-valid flag (seconds bit 7) is set by reset and by the command reset. Writing the seconds register with bit 7 = 0 clears it. Writing with bit 7 = 1 and normal counting leave it unchanged.
- R10: A control write whose bits 6, 4 and 3 are all 1 restores the full R2 state, whatever the other bits hold. A control write without all three of those bits only loads bits 5 and 2.
- R11: With control bit 2 at 0, hours read and write as BCD 00 to 23. With it at 1, hours use bit 5 = PM and bits 4:0 = BCD 01 to 12, where 12 AM is midnight and 12 PM is noon. Both views show the same instant, and 11:59:59 PM rolls over to 12 AM of the next day.
- R12: Written bits above each field's width are discarded. The widths are 7 bits for seconds and minutes, 6 bits for hours (24-hour mode) and day, 3 bits for weekday, 5 bits for month and 8 bits for year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
Every cycle, the assertions check four things:
- a frozen clock changes no field except through writes;
- the prescaler sits at zero while frozen;
- the not-valid flag can only be cleared by a seconds write;
- a seconds wrap and a command reset land in the expected state, and unmapped reads return zero.

The month-length and leap-year table, the weekday and year carries and the 12/24-hour mapping are shown only by the bench's sweeps. The bench runs every month of all hundred years on both sides of the month end, and every hour in both views. The exact number of pulses before the first second after a release is also covered only by a bench scenario.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_FIRST = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_LAST  = 4'h8;

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_MDAY = 3'd3,
    F_WDAY = 3'd4,
    F_MON  = 3'd5,
    F_YEAR = 3'd6
  } field_e;

  // binary working copy of the calendar
  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [5:0] mday;
    logic [2:0] wday;
    logic [4:0] mon;
    logic [7:0] year;
  } cal_t;

  localparam cal_t CAL_INIT = '{sec: 7'd0, min: 7'd0, hour: 6'd0, mday: 6'd1,
                                wday: 3'd0, mon: 5'd1, year: 8'd0};

  function automatic logic [7:0] bcd2val(input logic [7:0] b);
    return ({4'b0, b[7:4]} * 8'd10) + {4'b0, b[3:0]};
  endfunction

  function automatic logic [7:0] val2bcd(input logic [7:0] v);
    return {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  function automatic logic [5:0] month_days(input logic [4:0] m, input logic [1:0] ylo);
    case (m)
      5'd2:                      return (ylo == 2'b00) ? 6'd29 : 6'd28;
      5'd4, 5'd6, 5'd9, 5'd11:   return 6'd30;
      default:                   return 6'd31;
    endcase
  endfunction

  // register image of the hour field in either view
  function automatic logic [7:0] hour_out(input logic [5:0] h, input logic h12);
    logic       pm;
    logic [5:0] hh;
    if (!h12) return val2bcd({2'b00, h});
    pm = (h >= 6'd12);
    hh = pm ? h - 6'd12 : h;
    if (hh == 6'd0) hh = 6'd12;
    return {2'b00, pm, 5'(val2bcd({2'b00, hh}))};
  endfunction

  function automatic logic [5:0] hour_in(input logic [7:0] w, input logic h12);
    logic [7:0] hh;
    if (!h12) return 6'(bcd2val(w & 8'h3F));
    hh = bcd2val(w & 8'h1F);
    if (hh == 8'd12) hh = 8'd0;
    return 6'(hh + (w[5] ? 8'd12 : 8'd0));
  endfunction
endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  input  logic osc_tick,
  output logic sec_tick
);
  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr || !run)      cnt <= '0;
    else if (osc_tick)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign sec_tick = run && osc_tick && (cnt == LAST);

  AST_PRESC_HELD: assert property (@(posedge clk) disable iff (clr)
    !run |=> (cnt == '0)); // R8
endmodule

// File: rtl/tk_time_core.sv
module tk_time_core
  import tk_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       sec_tick,
  input  logic       tw_en,
  input  field_e     tw_field,
  input  logic [7:0] tw_val,
  input  logic       osf_clr,
  output cal_t       cal,
  output logic       osf
);
  cal_t nxt;

  always_comb begin
    nxt = cal;
    if (cal.sec >= 7'd59) begin
      nxt.sec = 7'd0;
      if (cal.min >= 7'd59) begin
        nxt.min = 7'd0;
        if (cal.hour >= 6'd23) begin
          nxt.hour = 6'd0;
          nxt.wday = (cal.wday >= 3'd6) ? 3'd0 : cal.wday + 3'd1;
          if (cal.mday >= month_days(cal.mon, cal.year[1:0])) begin
            nxt.mday = 6'd1;
            if (cal.mon >= 5'd12) begin
              nxt.mon  = 5'd1;
              nxt.year = (cal.year >= 8'd99) ? 8'd0 : cal.year + 8'd1;
            end else begin
              nxt.mon = cal.mon + 5'd1;
            end
          end else begin
            nxt.mday = cal.mday + 6'd1;
          end
        end else begin
          nxt.hour = cal.hour + 6'd1;
        end
      end else begin
        nxt.min = cal.min + 7'd1;
      end
    end else begin
      nxt.sec = cal.sec + 7'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cal <= CAL_INIT;
    end else if (tw_en) begin
      case (tw_field)
        F_SEC:   cal.sec  <= tw_val[6:0];
        F_MIN:   cal.min  <= tw_val[6:0];
        F_HOUR:  cal.hour <= tw_val[5:0];
        F_MDAY:  cal.mday <= tw_val[5:0];
        F_WDAY:  cal.wday <= tw_val[2:0];
        F_MON:   cal.mon  <= tw_val[4:0];
        F_YEAR:  cal.year <= tw_val;
        default: ;
      endcase
    end else if (sec_tick) begin
      cal <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (clr)          osf <= 1'b1;
    else if (osf_clr) osf <= 1'b0;
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (clr)
    (sec_tick && !tw_en && cal.sec == 7'd59) |=> (cal.sec == 7'd0)); // R3
  AST_OSF_STICKY: assert property (@(posedge clk) disable iff (clr)
    (osf && !osf_clr) |=> osf); // R9
endmodule

// File: rtl/tk_readview.sv
module tk_readview
  import tk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  cal_t              cal,
  input  logic              osf,
  input  logic              ctl_stop,
  input  logic              ctl_h12,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] view;

  always_comb begin
    case (addr)
      4'h0:    view = {2'b00, ctl_stop, 2'b00, ctl_h12, 2'b00};
      4'h2:    view = {osf, 7'(val2bcd({1'b0, cal.sec}))};
      4'h3:    view = {1'b0, 7'(val2bcd({1'b0, cal.min}))};
      4'h4:    view = hour_out(cal.hour, ctl_h12);
      4'h5:    view = val2bcd({2'b00, cal.mday});
      4'h6:    view = {5'b0, cal.wday};
      4'h7:    view = val2bcd({3'b000, cal.mon});
      4'h8:    view = val2bcd(cal.year);
      default: view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= view;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != ADR_CTRL && (addr < ADR_FIRST || addr > ADR_LAST)) |=> (rdata == '0)); // R1
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              osc_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic       ctl_stop, ctl_h12;
  logic       ctl_wr, swrst, clr, is_time, tw_en, osf_clr, sec_tick, osf;
  field_e     tw_field;
  logic [7:0] tw_val;
  cal_t       cal;

  assign ctl_wr   = wr_en && (addr == ADR_CTRL);
  assign swrst    = ctl_wr && wdata[6] && wdata[4] && wdata[3];
  assign clr      = rst || swrst;
  assign is_time  = (addr >= ADR_FIRST) && (addr <= ADR_LAST);
  assign tw_en    = wr_en && is_time;
  assign tw_field = field_e'(3'(addr - ADR_FIRST));
  assign osf_clr  = tw_en && (tw_field == F_SEC) && !wdata[7];

  always_comb begin
    case (tw_field)
      F_SEC, F_MIN: tw_val = bcd2val(wdata & 8'h7F);
      F_HOUR:       tw_val = {2'b00, hour_in(wdata, ctl_h12)};
      F_MDAY:       tw_val = bcd2val(wdata & 8'h3F);
      F_WDAY:       tw_val = {5'b0, wdata[2:0]};
      F_MON:        tw_val = bcd2val(wdata & 8'h1F);
      default:      tw_val = bcd2val(wdata);
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      ctl_stop <= 1'b0;
      ctl_h12  <= 1'b0;
    end else if (ctl_wr) begin
      ctl_stop <= wdata[5];
      ctl_h12  <= wdata[2];
    end
  end

  tk_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk(clk), .clr(clr), .run(!ctl_stop), .osc_tick(osc_tick), .sec_tick(sec_tick)
  );

  tk_time_core u_core (
    .clk(clk), .clr(clr), .sec_tick(sec_tick), .tw_en(tw_en), .tw_field(tw_field),
    .tw_val(tw_val), .osf_clr(osf_clr), .cal(cal), .osf(osf)
  );

  tk_readview u_view (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .cal(cal), .osf(osf),
    .ctl_stop(ctl_stop), .ctl_h12(ctl_h12), .rdata(rdata)
  );

  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (ctl_stop && !wr_en) |=> $stable(cal)); // R8
  AST_CMD_RESET: assert property (@(posedge clk) disable iff (rst)
    swrst |=> (osf && cal == CAL_INIT && !ctl_stop && !ctl_h12)); // R10
endmodule

// File: tb/bcd_timekeeper_tb.sv
`timescale 1ns/1ps
module bcd_timekeeper_tb;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  int         n_tests = 0;
  int         n_fail = 0;
  logic [7:0] got;

  always #2.5 clk = ~clk;

  bcd_timekeeper #(.PRESCALE(DIV)) u_dut (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] twelve(input int h);
    int hh;
    hh = h % 12;
    if (hh == 0) hh = 12;
    return ((h >= 12) ? 8'h20 : 8'h00) | bcd(hh);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_tick = 1'b1;
    end
    @(negedge clk); osc_tick = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    n_tests++;
    if (d !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%0h actual=%02h expected=%02h", req, a, d, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] s, mi, h, dm, wd, mo, y, input logic [7:0] ctl);
    wr(4'h0, 8'h20 | (ctl & 8'h04));
    wr(4'h2, s); wr(4'h3, mi); wr(4'h4, h); wr(4'h5, dm);
    wr(4'h6, wd); wr(4'h7, mo); wr(4'h8, y);
    wr(4'h0, ctl);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    chk("R2", 4'h0, 8'h00); chk("R2", 4'h2, 8'h80); chk("R2", 4'h3, 8'h00);
    chk("R2", 4'h4, 8'h00); chk("R2", 4'h5, 8'h01); chk("R2", 4'h6, 8'h00);
    chk("R2", 4'h7, 8'h01); chk("R2", 4'h8, 8'h00);

    // R1 unmapped space and control readback
    wr(4'h1, 8'hFF); wr(4'h9, 8'hFF); wr(4'hF, 8'hFF);
    chk("R1", 4'h1, 8'h00); chk("R1", 4'h9, 8'h00); chk("R1", 4'hF, 8'h00);
    chk("R1", 4'h5, 8'h01);
    wr(4'h0, 8'hA7);
    chk("R1", 4'h0, 8'h24);
    wr(4'h0, 8'h00);

    // R9 not-valid flag
    wr(4'h2, 8'h85);
    chk("R9", 4'h2, 8'h85);
    wr(4'h2, 8'h05);
    chk("R9", 4'h2, 8'h05);
    pulse(DIV);
    chk("R9", 4'h2, 8'h06);

    // R3 carries
    set_time(8'h59, 8'h59, 8'h00, 8'h10, 8'h02, 8'h03, 8'h21, 8'h00);
    pulse(DIV);
    chk("R3", 4'h2, 8'h00); chk("R3", 4'h3, 8'h00); chk("R3", 4'h4, 8'h01);
    chk("R3", 4'h5, 8'h10);
    set_time(8'h58, 8'h07, 8'h05, 8'h10, 8'h02, 8'h03, 8'h21, 8'h00);
    pulse(DIV);
    chk("R3", 4'h2, 8'h59); chk("R3", 4'h3, 8'h07);

    // R8 freeze and prescaler restart
    pulse(2);
    wr(4'h0, 8'h20);
    pulse(3 * DIV);
    chk("R8", 4'h2, 8'h59);
    wr(4'h0, 8'h00);
    pulse(DIV - 1);
    chk("R8", 4'h2, 8'h59);
    pulse(1);
    chk("R8", 4'h2, 8'h00);
    chk("R8", 4'h3, 8'h08);

    // R4 R5 R6 R7 sweep of every month end of every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int d, wd;
        d  = dim(m, y);
        wd = (y + m) % 7;
        set_time(8'h59, 8'h59, 8'h23, bcd(d - 1), 8'(wd), bcd(m), bcd(y), 8'h00);
        pulse(DIV);
        chk("R4", 4'h5, bcd(d));
        chk("R7", 4'h6, 8'((wd + 1) % 7));
        set_time(8'h59, 8'h59, 8'h23, bcd(d), 8'(wd), bcd(m), bcd(y), 8'h00);
        pulse(DIV);
        chk((m == 2) ? "R5" : "R4", 4'h5, 8'h01);
        chk("R6", 4'h7, bcd((m == 12) ? 1 : m + 1));
        chk("R6", 4'h8, bcd((m == 12) ? (y + 1) % 100 : y));
        chk("R7", 4'h6, 8'((wd + 1) % 7));
      end
    end

    // R11 hour views
    for (int h = 0; h < 24; h++) begin
      wr(4'h0, 8'h20); wr(4'h4, bcd(h)); wr(4'h0, 8'h24);
      chk("R11", 4'h4, twelve(h));
      wr(4'h4, twelve(h)); wr(4'h0, 8'h20);
      chk("R11", 4'h4, bcd(h));
    end
    set_time(8'h59, 8'h59, 8'h31, 8'h14, 8'h03, 8'h05, 8'h24, 8'h04);
    pulse(DIV);
    chk("R11", 4'h4, 8'h12); chk("R11", 4'h5, 8'h15);
    set_time(8'h59, 8'h59, 8'h11, 8'h14, 8'h03, 8'h05, 8'h24, 8'h04);
    pulse(DIV);
    chk("R11", 4'h4, 8'h32); chk("R11", 4'h5, 8'h14);

    // R12 field masking
    wr(4'h0, 8'h20);
    wr(4'h7, 8'hE5); chk("R12", 4'h7, 8'h05);
    wr(4'h6, 8'hFD); chk("R12", 4'h6, 8'h05);
    wr(4'h3, 8'hC2); chk("R12", 4'h3, 8'h42);
    wr(4'h5, 8'hD7); chk("R12", 4'h5, 8'h17);

    // R10 command reset
    set_time(8'h33, 8'h44, 8'h15, 8'h20, 8'h04, 8'h06, 8'h50, 8'h00);
    wr(4'h0, 8'h18);
    chk("R10", 4'h2, 8'h33); chk("R10", 4'h0, 8'h00);
    wr(4'h0, 8'h58);
    chk("R10", 4'h2, 8'h80); chk("R10", 4'h3, 8'h00); chk("R10", 4'h4, 8'h00);
    chk("R10", 4'h5, 8'h01); chk("R10", 4'h7, 8'h01); chk("R10", 4'h8, 8'h00);
    set_time(8'h12, 8'h44, 8'h15, 8'h20, 8'h04, 8'h06, 8'h50, 8'h00);
    wr(4'h0, 8'hFF);
    chk("R10", 4'h0, 8'h00); chk("R10", 4'h2, 8'h80); chk("R10", 4'h6, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule